// File: doc/BRIEF.md
# DDR2 Read Latency Timing Generator

This block works out, clock by clock, when read data from a DDR2-style memory is due. A mode-register load carries the CAS latency in three address bits. The additive (posted) latency arrives on a separate input and is captured by the same load strobe. Each READ command sampled on a rising clock edge is scheduled to start its burst AL + CL edges later.

For every clock cycle, the block drives a valid bit and a 2-bit beat index for the rising half and for the falling half. A memory controller or a behavioural memory model can use these to launch or capture a four-beat burst on the right edges. A latency load with an encoding outside the legal set is rejected, and an error pulse is raised.

Scheduling uses a slot pipeline rather than one counter. Bursts that are already scheduled keep their timing when the latency is reprogrammed, and READs issued every two clocks produce gap-free valid windows.

Top module: `rdLatGen`

## Requirements
- R1: A synchronous active-high reset clears every scheduled burst and drives all outputs low. It also sets the CAS latency to 3 and the additive latency to 0.
- R2: The CAS latency is read from `modeAddr[6:4]` as plain binary. Codes 3 through 7 are legal and set CL equal to the code.
- R3: `alSetting` values 0 to 4 are captured as the additive latency on the same edge as a legal mode load.
- R4: With AL = 0, a READ sampled on edge n makes the cycle that begins at edge n + CL the first data cycle. In that cycle `validRise` = 1 with `beatRise` = 0.
- R5: With AL > 0, the first data cycle begins at edge n + AL + CL.
- R6: Each burst is four beats over two cycles. The first cycle carries beats 0 and 1 on the rise and fall halves. The second cycle carries beats 2 and 3. Both valid bits are high in both cycles.
- R7: A load with CL code 0, 1 or 2 is rejected. `latErr` is high for exactly the one cycle after that load edge, and both latencies stay as they were.
- R8: A load with `alSetting` above 4 is rejected in the same way as R7, even when its CL code is legal.
- R9: READs issued every two clocks give a continuous run of valid cycles, with beat indexes 0,2,0,2 on the rising half.
- R10: A new load does not alter bursts already scheduled. A READ sampled on the same edge as a load still uses the old latency.
- R11: `latErr` stays low after a legal load and when no load is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| modeLoad | input | 1 | Mode-register load strobe |
| modeAddr | input | 14 | Mode-register address word; bits 6:4 hold the CL code |
| alSetting | input | 3 | Additive latency captured with a load |
| readCmd | input | 1 | READ command sampled on this edge |
| validRise | output | 1 | Data beat due on the rising half of this cycle |
| validFall | output | 1 | Data beat due on the falling half of this cycle |
| beatRise | output | 2 | Beat index for the rising half |
| beatFall | output | 2 | Beat index for the falling half |
| latErr | output | 1 | One-cycle pulse after a rejected load |

## Verification
A mode load and a READ can land on the same edge. The READ must then be timed with the latency in force before that edge. The bench provokes this by asserting `readCmd` together with `modeLoad`, which also switches the latency. A behavioural queue model schedules the READ with the old latency and compares the start cycle and beat indexes on every clock. A second overlap comes from the pipeline: the tail of one burst and the head of the next fall in adjacent cycles when READs arrive every two clocks. The model is compared every cycle across several latency settings and across a latency change with a burst in flight.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;
  // latency limits
  localparam int MIN_CL   = 3;
  localparam int MAX_CL   = 7;
  localparam int MAX_AL   = 4;
  localparam int CL_LSB   = 4;
  localparam int CL_W     = $clog2(MAX_CL + 1);
  localparam int AL_W     = 3;
  localparam int ADDR_W   = 14;
  localparam int BEAT_W   = 2;
  // scheduling pipeline
  localparam int DEPTH    = MAX_CL + MAX_AL;
  localparam int SLOT_W   = $clog2(DEPTH + 1);

  typedef struct packed {
    logic              launch;
    logic [SLOT_W-1:0] slot;
  } schedStrobe_t;
endpackage

// File: rtl/rdLatCtrl.sv
module rdLatCtrl
  import rdlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              modeLoad,
  input  logic [ADDR_W-1:0] modeAddr,
  input  logic [AL_W-1:0]   alSetting,
  input  logic              readCmd,
  output schedStrobe_t      strobe,
  output logic              latErr
);
  logic [CL_W-1:0] clReg;
  logic [AL_W-1:0] alReg;
  logic [CL_W-1:0] clCode;
  logic            clBad;
  logic            alBad;
  logic            loadOk;

  assign clCode = modeAddr[CL_LSB +: CL_W];
  assign clBad  = (int'(clCode) < MIN_CL) || (int'(clCode) > MAX_CL);
  assign alBad  = int'(alSetting) > MAX_AL;
  assign loadOk = modeLoad && !clBad && !alBad;

  always_ff @(posedge clk) begin
    if (rst) begin
      clReg  <= CL_W'(MIN_CL);
      alReg  <= '0;
      latErr <= 1'b0;
    end else begin
      latErr <= modeLoad && (clBad || alBad);
      if (loadOk) begin
        clReg <= clCode;
        alReg <= alSetting;
      end
    end
  end

  // a burst launched now lands in slot (latency - 1)
  always_comb begin
    strobe.launch = readCmd;
    strobe.slot   = SLOT_W'(clReg) + SLOT_W'(alReg) - SLOT_W'(1);
  end

  // R7
  reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (modeLoad && clBad) |=> ($stable(clReg) && $stable(alReg) && latErr));
  // R2
  cl_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(clReg) >= MIN_CL) && (int'(clReg) <= MAX_CL));
  // R3
  al_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(alReg) <= MAX_AL);
  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    latErr |-> $past(modeLoad));
endmodule

// File: rtl/rdLatPipe.sv
module rdLatPipe
  import rdlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  schedStrobe_t      strobe,
  output logic              validRise,
  output logic              validFall,
  output logic [BEAT_W-1:0] beatRise,
  output logic [BEAT_W-1:0] beatFall
);
  logic [DEPTH-1:0] slots;
  logic [DEPTH-1:0] slotsNext;
  logic             firstHalf;
  logic             secondHalf;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      logic shifted;
      if (gi == DEPTH - 1) begin : g_top
        assign shifted = 1'b0;
      end else begin : g_mid
        assign shifted = slots[gi+1];
      end
      assign slotsNext[gi] = shifted ||
        (strobe.launch && (int'(strobe.slot) == gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      slots      <= '0;
      firstHalf  <= 1'b0;
      secondHalf <= 1'b0;
    end else begin
      slots      <= slotsNext;
      firstHalf  <= slots[0];
      secondHalf <= firstHalf;
    end
  end

  always_comb begin
    validRise = firstHalf || secondHalf;
    validFall = validRise;
    beatRise  = firstHalf ? BEAT_W'(0) : BEAT_W'(2);
    if (!validRise) beatRise = '0;
    beatFall  = validRise ? beatRise + BEAT_W'(1) : '0;
  end

  // R4
  slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.launch |-> (int'(strobe.slot) < DEPTH));
  // R6
  beat_order_chk: assert property (@(posedge clk) disable iff (rst)
    (validRise && beatRise == BEAT_W'(0)) |=> validRise);
  // R6
  fall_follows_chk: assert property (@(posedge clk) disable iff (rst)
    validFall |-> (validRise && beatFall == beatRise + BEAT_W'(1)));
endmodule

// File: rtl/rdLatGen.sv
module rdLatGen
  import rdlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              modeLoad,
  input  logic [ADDR_W-1:0] modeAddr,
  input  logic [AL_W-1:0]   alSetting,
  input  logic              readCmd,
  output logic              validRise,
  output logic              validFall,
  output logic [BEAT_W-1:0] beatRise,
  output logic [BEAT_W-1:0] beatFall,
  output logic              latErr
);
  schedStrobe_t strobe;

  rdLatCtrl u_ctrl (
    .clk(clk), .rst(rst), .modeLoad(modeLoad), .modeAddr(modeAddr),
    .alSetting(alSetting), .readCmd(readCmd), .strobe(strobe), .latErr(latErr)
  );

  rdLatPipe u_pipe (
    .clk(clk), .rst(rst), .strobe(strobe), .validRise(validRise),
    .validFall(validFall), .beatRise(beatRise), .beatFall(beatFall)
  );
endmodule

// File: tb/rdLatGen_tb.sv
module rdLatGen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        modeLoad = 1'b0;
  logic [13:0] modeAddr = '0;
  logic [2:0]  alSetting = '0;
  logic        readCmd = 1'b0;
  logic        validRise, validFall, latErr;
  logic [1:0]  beatRise, beatFall;

  rdLatGen u_dut (
    .clk(clk), .rst(rst), .modeLoad(modeLoad), .modeAddr(modeAddr),
    .alSetting(alSetting), .readCmd(readCmd), .validRise(validRise),
    .validFall(validFall), .beatRise(beatRise), .beatFall(beatFall),
    .latErr(latErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int mCl = 3;
  int mAl = 0;
  int starts[$];
  logic expErr = 1'b0;
  string tag = "R1";
  bit done = 1'b0;

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural model step at a rising edge, then compare at the falling edge
  task automatic tick();
    int eV, eB;
    @(posedge clk);
    cyc++;
    if (rst) begin
      starts.delete();
      mCl = 3; mAl = 0; expErr = 1'b0;
    end else begin
      int code;
      if (readCmd) starts.push_back(cyc + mCl + mAl);
      code = int'(modeAddr[6:4]);
      expErr = modeLoad && (code < 3 || int'(alSetting) > 4);
      if (modeLoad && !expErr) begin mCl = code; mAl = int'(alSetting); end
    end
    eV = 0; eB = 0;
    foreach (starts[i]) begin
      if (starts[i] == cyc) begin eV = 1; eB = 0; end
      else if (starts[i] + 1 == cyc) begin eV = 1; eB = 2; end
    end
    while (starts.size() > 0 && starts[0] + 1 < cyc) void'(starts.pop_front());
    @(negedge clk);
    check({tag, " validRise"}, int'(validRise), eV);
    check({tag, " validFall"}, int'(validFall), eV);
    check({tag, " R6 beatRise"}, int'(beatRise), eB);
    check({tag, " R6 beatFall"}, int'(beatFall), eV ? eB + 1 : 0);
    check("R7 R8 R11 latErr", int'(latErr), int'(expErr));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rd();
    readCmd = 1'b1; tick(); readCmd = 1'b0;
  endtask

  task automatic load(int code, int al, bit withRead);
    modeLoad = 1'b1; modeAddr = 14'(code << 4) | 14'h2003; alSetting = 3'(al);
    readCmd = withRead;
    tick();
    modeLoad = 1'b0; readCmd = 1'b0; modeAddr = '0; alSetting = '0;
  endtask

  initial begin
    tag = "R1"; idle(3); rst = 1'b0; idle(2);
    tag = "R4"; rd(); idle(8);
    tag = "R2"; load(5, 0, 0); rd(); idle(9); load(7, 0, 0); rd(); idle(10);
    tag = "R5"; load(4, 3, 0); rd(); idle(11);
    tag = "R3"; load(7, 4, 0); rd(); idle(14);
    tag = "R9"; load(3, 0, 0);
    for (int k = 0; k < 5; k++) begin rd(); idle(1); end
    idle(6);
    load(6, 2, 0);
    for (int k = 0; k < 4; k++) begin rd(); idle(1); end
    idle(12);
    tag = "R7"; load(4, 0, 0); load(1, 0, 0); rd(); idle(8);
    load(0, 2, 0); idle(1); load(2, 0, 0); rd(); idle(8);
    tag = "R8"; load(5, 6, 0); rd(); idle(8); load(3, 7, 0); idle(2);
    tag = "R10"; load(7, 4, 0); rd(); load(3, 0, 0); idle(2); rd(); idle(12);
    load(6, 1, 1); rd(); idle(12);
    tag = "R11"; load(3, 0, 0); idle(3);
    tag = "R1"; readCmd = 1'b1; tick(); readCmd = 1'b0; idle(1);
    rst = 1'b1; idle(2); rst = 1'b0; idle(6);
    rd(); idle(6);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule